// File: doc/BRIEF.md
# Delegated Counter Alias Gateway

This block decodes supervisor accesses made through an indirect register window into a bank of delegated performance counters. The caller presents a 32-bit select index and an alias slot number (1 to 6), with a read strobe, a write strobe and write data. It also presents the current privilege mode, the virtualization flag, a per-counter delegation mask, a global delegation enable, a state-enable gate bit and a strap that says whether the machine runs with 64-bit registers.

Selects from 0x40 to 0x5F address counter `i = select - 0x40`. Each counter has a 64-bit count register and a 64-bit configuration/event register. The block checks every access against a layered set of rules. The outcome is either a legal read or write of the counter file, an illegal-instruction code, or a virtual-instruction code. The result appears on registered outputs one clock after the access.

The internal counter file only holds values so that alias reads and writes can be observed. Nothing in the block counts events.

Top module: `dctr_alias_gw`

## Requirements
- R1: With 32-bit registers, a legal access in select range 0x40..0x5F uses the following slots. Slot 1 reaches bits 31:0 of the count. Slot 4 reaches bits 63:32 of the count. Slot 2 reaches bits 31:0 of the configuration. Slot 5 reaches bits 63:32 of the configuration. Write data comes from bits 31:0 and read data is zero-extended. `exc_o` and `rdata_o` show the result one clock after the access, with code 0 = none, 1 = illegal-instruction, 2 = virtual-instruction.
- R2: With 64-bit registers (`xlen64_i`=1), slots 1 and 2 move all 64 bits. Slots 4 and 5 raise code 1 in the select range.
- R3: In M or S mode (privilege code 3 or 1, not virtualized), any in-range access raises code 1 while `cde_i`=0.
- R4: In M or S mode, slots 3 and 6 raise code 1 in the select range. The unused encodings 0 and 7 also raise code 1.
- R5: Select 0x41 (the time index) raises code 1. So does any counter whose bit in `deleg_mask_i` is 0. Counter 1 is never written.
- R6: A counter whose bit in the parameter `FEAT_MASK` is 0 raises code 1 from M or S.
- R7: Bit 62 of every configuration register reads as 0 through the alias slots. Writes to that bit are dropped. In the upper half this is bit 30.
- R8: From virtualized S mode with an in-range select, an access raises code 1 when `cde_i`=0 and code 2 when `cde_i`=1. From virtualized U mode, any access raises code 2. In M mode the virtualization flag has no effect.
- R9: When `stateen_i`=0, any access from below M mode raises code 1. This check comes before every other rule. M-mode accesses are not affected.
- R10: An access that raises an exception changes no counter state, and `rdata_o` is 0 with it.
- R11: An access from non-virtualized U mode (code 0) raises code 1. From M or S mode, a select outside 0x40..0x5F gives code 0, read data 0, and no state change. A cycle with no strobe gives code 0 and read data 0.
- R12: Reset clears every count and configuration register. It also drives `exc_o` and `rdata_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sel_i | input | 32 | Indirect select index |
| slot_i | input | 3 | Alias slot number |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 64 | Write data |
| priv_i | input | 2 | Privilege mode: 0 U, 1 S, 3 M |
| virt_i | input | 1 | Virtualization flag |
| deleg_mask_i | input | 32 | Per-counter delegation bits |
| cde_i | input | 1 | Global counter delegation enable |
| stateen_i | input | 1 | State-enable gate bit |
| xlen64_i | input | 1 | 64-bit register width strap |
| rdata_o | output | 64 | Registered read data |
| exc_o | output | 2 | Registered exception code |

## Verification
The bench builds the block with `FEAT_MASK` = 32'h7FFF_FFF9, so counters 2 and 31 are reported absent. With that value, a feature miss can be checked both at the lowest present index and at the top of the select range. The counters next to those holes, 0 and 3, stay present and usable. Under that value the bench compares every clock against a behavioural model in three situations:
- toggling of the XLEN strap,
- the enable and gate inputs,
- all privilege/virtualization pairs.

// File: rtl/dctr_alias_pkg.sv
package dctr_alias_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned DATA_W   = 64;
    localparam int unsigned HALF_W   = DATA_W / 2;
    localparam int unsigned MINH_BIT = 62;
    localparam int unsigned TIME_IDX = 1;
    localparam logic [31:0] SEL_BASE = 32'h0000_0040;

    localparam logic [1:0] PRV_U = 2'd0;
    localparam logic [1:0] PRV_S = 2'd1;
    localparam logic [1:0] PRV_M = 2'd3;

    localparam logic [2:0] SLOT_CTR_LO = 3'd1;
    localparam logic [2:0] SLOT_CFG_LO = 3'd2;
    localparam logic [2:0] SLOT_RSV_A  = 3'd3;
    localparam logic [2:0] SLOT_CTR_HI = 3'd4;
    localparam logic [2:0] SLOT_CFG_HI = 3'd5;
    localparam logic [2:0] SLOT_RSV_B  = 3'd6;

    typedef enum logic [1:0] {
        EXC_NONE    = 2'd0,
        EXC_ILLEGAL = 2'd1,
        EXC_VIRTUAL = 2'd2
    } exc_e;
endpackage

// File: rtl/dctr_alias_decode.sv
module dctr_alias_decode
    import dctr_alias_pkg::*;
#(
    parameter int unsigned          N_CTR     = 32,
    parameter logic [N_CTR-1:0]     FEAT_MASK = 32'hFFFF_FFFD,
    localparam int unsigned         IDXW      = $clog2(N_CTR)
) (
    input  logic [31:0]      sel_i,
    input  logic [2:0]       slot_i,
    input  logic             acc_i,
    input  logic [1:0]       priv_i,
    input  logic             virt_i,
    input  logic [N_CTR-1:0] mask_i,
    input  logic             cde_i,
    input  logic             stateen_i,
    input  logic             xlen64_i,
    output exc_e             exc_o,
    output logic             hit_o,
    output logic [IDXW-1:0]  idx_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [31:0] off;
    logic        in_range;
    logic        below_m;
    logic        virt_eff;
    logic        slot_ok;

    always_comb begin
        off      = sel_i - SEL_BASE;
        in_range = (sel_i >= SEL_BASE) && (off < 32'(N_CTR));
        idx_o    = off[IDXW-1:0];
        below_m  = (priv_i != PRV_M);
        virt_eff = virt_i && below_m;
        slot_ok  = (slot_i == SLOT_CTR_LO) || (slot_i == SLOT_CFG_LO) ||
                   (!xlen64_i && ((slot_i == SLOT_CTR_HI) || (slot_i == SLOT_CFG_HI)));
    end

    // Layered check: gate, mode, range, virtualization, then per-counter rules
    always_comb begin
        exc_o = EXC_NONE;
        hit_o = 1'b0;
        if (acc_i) begin
            if (below_m && !stateen_i) begin
                exc_o = EXC_ILLEGAL;
            end else if (virt_eff && (priv_i != PRV_S)) begin
                exc_o = EXC_VIRTUAL;
            end else if (!virt_eff && (priv_i != PRV_S) && (priv_i != PRV_M)) begin
                exc_o = EXC_ILLEGAL;
            end else if (!in_range) begin
                exc_o = EXC_NONE;
            end else if (virt_eff) begin
                exc_o = cde_i ? EXC_VIRTUAL : EXC_ILLEGAL;
            end else if (!cde_i || !slot_ok || (idx_o == IDXW'(TIME_IDX)) ||
                         !mask_i[idx_o] || !FEAT_MASK[idx_o]) begin
                exc_o = EXC_ILLEGAL;
            end else begin
                hit_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dctr_alias_file.sv
module dctr_alias_file
    import dctr_alias_pkg::*;
#(
    parameter int unsigned  N_CTR = 32,
    localparam int unsigned IDXW  = $clog2(N_CTR)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [IDXW-1:0]   idx_i,
    input  logic [2:0]        slot_i,
    input  logic              xlen64_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic [N_CTR-1:0][DATA_W-1:0] ctr;
        logic [N_CTR-1:0][DATA_W-1:0] cfg;
    } file_t;

    file_t st_d, st_q;
    logic [DATA_W-1:0] ctr_sel, cfg_sel;

    always_comb begin
        ctr_sel = st_q.ctr[idx_i];
        cfg_sel = st_q.cfg[idx_i];
        cfg_sel[MINH_BIT] = 1'b0;
        unique case (slot_i)
            SLOT_CTR_LO: rdata_o = xlen64_i ? ctr_sel : {{HALF_W{1'b0}}, ctr_sel[HALF_W-1:0]};
            SLOT_CTR_HI: rdata_o = {{HALF_W{1'b0}}, ctr_sel[DATA_W-1:HALF_W]};
            SLOT_CFG_LO: rdata_o = xlen64_i ? cfg_sel : {{HALF_W{1'b0}}, cfg_sel[HALF_W-1:0]};
            SLOT_CFG_HI: rdata_o = {{HALF_W{1'b0}}, cfg_sel[DATA_W-1:HALF_W]};
            default:     rdata_o = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            unique case (slot_i)
                SLOT_CTR_LO: begin
                    if (xlen64_i) st_d.ctr[idx_i] = wdata_i;
                    else          st_d.ctr[idx_i][HALF_W-1:0] = wdata_i[HALF_W-1:0];
                end
                SLOT_CTR_HI: st_d.ctr[idx_i][DATA_W-1:HALF_W] = wdata_i[HALF_W-1:0];
                SLOT_CFG_LO: begin
                    if (xlen64_i) st_d.cfg[idx_i] = wdata_i;
                    else          st_d.cfg[idx_i][HALF_W-1:0] = wdata_i[HALF_W-1:0];
                end
                SLOT_CFG_HI: st_d.cfg[idx_i][DATA_W-1:HALF_W] = wdata_i[HALF_W-1:0];
                default: ;
            endcase
            st_d.cfg[idx_i][MINH_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    AST_FILE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_i |=> $stable(st_q)); // R10

    AST_TIME_UNTOUCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ctr[TIME_IDX] == '0) && (st_q.cfg[TIME_IDX] == '0)); // R5

    for (genvar g = 0; g < N_CTR; g++) begin : g_minh
        AST_MINH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
            st_q.cfg[g][MINH_BIT] == 1'b0); // R7
    end
endmodule

// File: rtl/dctr_alias_gw.sv
module dctr_alias_gw
    import dctr_alias_pkg::*;
#(
    parameter int unsigned      N_CTR     = 32,
    parameter logic [N_CTR-1:0] FEAT_MASK = 32'hFFFF_FFFD
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [31:0]       sel_i,
    input  logic [2:0]        slot_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [63:0]       wdata_i,
    input  logic [1:0]        priv_i,
    input  logic              virt_i,
    input  logic [N_CTR-1:0]  deleg_mask_i,
    input  logic              cde_i,
    input  logic              stateen_i,
    input  logic              xlen64_i,
    output logic [63:0]       rdata_o,
    output logic [1:0]        exc_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned IDXW = $clog2(N_CTR);

    typedef struct packed {
        exc_e              exc;
        logic [DATA_W-1:0] rdata;
    } out_t;

    out_t              out_d, out_q;
    exc_e              dec_exc;
    logic              dec_hit;
    logic [IDXW-1:0]   dec_idx;
    logic [DATA_W-1:0] file_rdata;
    logic              file_we;
    logic              acc;

    assign acc     = rd_i || wr_i;
    assign file_we = wr_i && dec_hit;

    dctr_alias_decode #(
        .N_CTR     (N_CTR),
        .FEAT_MASK (FEAT_MASK)
    ) decode_i (
        .sel_i     (sel_i),
        .slot_i    (slot_i),
        .acc_i     (acc),
        .priv_i    (priv_i),
        .virt_i    (virt_i),
        .mask_i    (deleg_mask_i),
        .cde_i     (cde_i),
        .stateen_i (stateen_i),
        .xlen64_i  (xlen64_i),
        .exc_o     (dec_exc),
        .hit_o     (dec_hit),
        .idx_o     (dec_idx)
    );

    dctr_alias_file #(
        .N_CTR (N_CTR)
    ) file_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (file_we),
        .idx_i    (dec_idx),
        .slot_i   (slot_i),
        .xlen64_i (xlen64_i),
        .wdata_i  (wdata_i),
        .rdata_o  (file_rdata)
    );

    always_comb begin
        out_d.exc   = dec_exc;
        out_d.rdata = (rd_i && dec_hit) ? file_rdata : '0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign rdata_o = out_q.rdata;
    assign exc_o   = out_q.exc;

    logic in_rng;
    assign in_rng = (sel_i >= SEL_BASE) && (sel_i < SEL_BASE + 32'(N_CTR));

    AST_WR_ONLY_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        file_we |-> (dec_exc == EXC_NONE)); // R10

    AST_RDATA_ZERO_ON_EXC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_o != 2'd0) |-> (rdata_o == '0)); // R10

    AST_TIME_IDX_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc && priv_i == PRV_M && sel_i == SEL_BASE + 32'(TIME_IDX)) |=> (exc_o == 2'd1)); // R5

    AST_SLOT_RSV: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc && priv_i == PRV_M && in_rng && (slot_i == SLOT_RSV_A || slot_i == SLOT_RSV_B))
        |=> (exc_o == 2'd1)); // R4

    AST_XLEN64_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc && priv_i == PRV_M && in_rng && xlen64_i &&
         (slot_i == SLOT_CTR_HI || slot_i == SLOT_CFG_HI)) |=> (exc_o == 2'd1)); // R2

    AST_VU_VIRT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc && stateen_i && virt_i && priv_i == PRV_U) |=> (exc_o == 2'd2)); // R8

    AST_GATE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc && !stateen_i && priv_i != PRV_M) |=> (exc_o == 2'd1)); // R9
endmodule

// File: tb/dctr_alias_gw_tb.sv
module dctr_alias_gw_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [31:0] FEAT = 32'h7FFF_FFF9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] sel = '0;
    logic [2:0]  slot = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [63:0] wdata = '0;
    logic [1:0]  priv = 2'd3;
    logic        virt = 1'b0;
    logic [31:0] mask = '1;
    logic        cde = 1'b1, stateen = 1'b1, x64 = 1'b0;
    logic [63:0] rdata_o;
    logic [1:0]  exc_o;

    // next configuration, applied at the same edge as the next access
    logic [31:0] nx_mask = '1;
    logic        nx_cde = 1'b1, nx_stateen = 1'b1, nx_x64 = 1'b0;

    int total = 0, bad = 0;
    bit done = 1'b0;

    logic [63:0] m_ctr [32];
    logic [63:0] m_cfg [32];
    int          exp_exc;
    logic [63:0] exp_rd;
    bit          exp_valid = 1'b0;
    string       exp_tag = "";

    always #4 clk = ~clk;

    dctr_alias_gw #(.N_CTR(32), .FEAT_MASK(FEAT)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .slot_i(slot), .rd_i(rd), .wr_i(wr),
        .wdata_i(wdata), .priv_i(priv), .virt_i(virt), .deleg_mask_i(mask), .cde_i(cde),
        .stateen_i(stateen), .xlen64_i(x64), .rdata_o(rdata_o), .exc_o(exc_o));

    task automatic check(string tag, int e_exc, logic [63:0] e_rd);
        total++;
        if (int'(exc_o) != e_exc || rdata_o !== e_rd) begin
            bad++;
            $display("FAIL %s exc=%0d exp=%0d rdata=%h exp=%h", tag, exc_o, e_exc, rdata_o, e_rd);
        end
    endtask

    // Behavioural reference: decides the outcome of one access and updates the model
    task automatic model(logic [31:0] s, logic [2:0] sl, logic r, logic w, logic [63:0] d,
                         logic [1:0] p, logic v);
        int ex = 0;
        logic [63:0] val = '0;
        bit ok = 0;
        bit lower = (p != 2'd3);
        bit ve = v && lower;
        bit inr = (s >= 32'h40) && (s < 32'h60);
        int i = int'(s) - 64;
        if (r || w) begin
            if (lower && !stateen) ex = 1;
            else if (ve && p != 2'd1) ex = 2;
            else if (!ve && p == 2'd0) ex = 1;
            else if (!inr) ex = 0;
            else if (ve) ex = cde ? 2 : 1;
            else begin
                ok = cde && (i != 1) && mask[i] && FEAT[i] &&
                     (sl == 1 || sl == 2 || (!x64 && (sl == 4 || sl == 5)));
                if (!ok) ex = 1;
            end
        end
        if (ok) begin
            logic [63:0] c = m_cfg[i];
            c[62] = 1'b0;
            case (sl)
                3'd1: val = x64 ? m_ctr[i] : {32'h0, m_ctr[i][31:0]};
                3'd4: val = {32'h0, m_ctr[i][63:32]};
                3'd2: val = x64 ? c : {32'h0, c[31:0]};
                default: val = {32'h0, c[63:32]};
            endcase
            if (w) begin
                case (sl)
                    3'd1: if (x64) m_ctr[i] = d; else m_ctr[i][31:0] = d[31:0];
                    3'd4: m_ctr[i][63:32] = d[31:0];
                    3'd2: if (x64) m_cfg[i] = d; else m_cfg[i][31:0] = d[31:0];
                    default: m_cfg[i][63:32] = d[31:0];
                endcase
                m_cfg[i][62] = 1'b0;
            end
        end
        exp_exc = ex;
        exp_rd  = (ok && r) ? val : 64'h0;
    endtask

    task automatic step(string tag, logic [31:0] s, logic [2:0] sl, logic r, logic w,
                        logic [63:0] d, logic [1:0] p, logic v);
        @(negedge clk);
        if (exp_valid) check(exp_tag, exp_exc, exp_rd);
        sel = s; slot = sl; rd = r; wr = w; wdata = d; priv = p; virt = v;
        mask = nx_mask; cde = nx_cde; stateen = nx_stateen; x64 = nx_x64;
        model(s, sl, r, w, d, p, v);
        exp_valid = 1'b1;
        exp_tag = tag;
    endtask

    initial begin
        for (int k = 0; k < 32; k++) begin m_ctr[k] = '0; m_cfg[k] = '0; end
        repeat (3) @(negedge clk);
        check("R12 reset outputs", 0, 64'h0);
        rst_n = 1'b1;
        step("R12 counter cleared", 32'h40, 3'd1, 1, 0, 0, 2'd3, 0);
        step("R12 cfg cleared", 32'h5E, 3'd5, 1, 0, 0, 2'd3, 0);
        // R1 half access with 32-bit registers
        step("R1 write ctr lo", 32'h40, 3'd1, 0, 1, 64'h1111_2222_3333_4444, 2'd3, 0);
        step("R1 write ctr hi", 32'h40, 3'd4, 0, 1, 64'h0000_0000_AAAA_5555, 2'd3, 0);
        step("R1 read ctr lo", 32'h40, 3'd1, 1, 0, 0, 2'd3, 0);
        step("R1 read ctr hi", 32'h40, 3'd4, 1, 0, 0, 2'd3, 0);
        step("R7 write cfg lo", 32'h43, 3'd2, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 0);
        step("R7 write cfg hi", 32'h43, 3'd5, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 0);
        step("R7 read cfg hi", 32'h43, 3'd5, 1, 0, 0, 2'd3, 0);
        step("R1 read cfg lo", 32'h43, 3'd2, 1, 1, 64'h0000_0000_1234_5678, 2'd1, 0);
        step("R1 read cfg lo after", 32'h43, 3'd2, 1, 0, 0, 2'd1, 0);
        // R2 64-bit registers
        nx_x64 = 1'b1;
        step("R2 write ctr full", 32'h5E, 3'd1, 0, 1, 64'hDEAD_BEEF_0123_4567, 2'd3, 0);
        step("R2 read ctr full", 32'h5E, 3'd1, 1, 0, 0, 2'd3, 0);
        step("R7 write cfg full", 32'h5E, 3'd2, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 0);
        step("R7 read cfg full", 32'h5E, 3'd2, 1, 0, 0, 2'd3, 0);
        step("R2 hi slot illegal", 32'h5E, 3'd4, 1, 0, 0, 2'd3, 0);
        step("R2 cfg hi write illegal", 32'h5E, 3'd5, 0, 1, 64'h0, 2'd1, 0);
        step("R10 cfg unchanged", 32'h5E, 3'd2, 1, 0, 0, 2'd3, 0);
        nx_x64 = 1'b0;
        // R3 global enable
        nx_cde = 1'b0;
        step("R3 read with cde off", 32'h40, 3'd1, 1, 0, 0, 2'd3, 0);
        step("R3 write with cde off", 32'h40, 3'd1, 0, 1, 64'h9, 2'd1, 0);
        nx_cde = 1'b1;
        step("R10 unchanged after cde fault", 32'h40, 3'd1, 1, 0, 0, 2'd3, 0);
        // R4 reserved slots
        step("R4 slot 3", 32'h43, 3'd3, 1, 0, 0, 2'd3, 0);
        step("R4 slot 6", 32'h43, 3'd6, 1, 0, 0, 2'd1, 0);
        step("R4 slot 0", 32'h43, 3'd0, 0, 1, 64'h1, 2'd3, 0);
        step("R4 slot 7", 32'h43, 3'd7, 1, 0, 0, 2'd3, 0);
        // R5 time index and delegation mask
        step("R5 time index", 32'h41, 3'd1, 1, 0, 0, 2'd3, 0);
        step("R5 time index write", 32'h41, 3'd2, 0, 1, 64'h77, 2'd1, 0);
        nx_mask = 32'hFFFF_FFDF;
        step("R5 undelegated write", 32'h45, 3'd1, 0, 1, 64'h55, 2'd3, 0);
        nx_mask = '1;
        step("R10 undelegated unchanged", 32'h45, 3'd1, 1, 0, 0, 2'd3, 0);
        // R6 feature presence
        step("R6 counter 2 absent", 32'h42, 3'd1, 1, 0, 0, 2'd3, 0);
        step("R6 counter 31 absent", 32'h5F, 3'd2, 1, 0, 0, 2'd1, 0);
        step("R6 counter 3 present", 32'h43, 3'd1, 1, 0, 0, 2'd3, 0);
        // R8 virtualization
        nx_cde = 1'b0;
        step("R8 VS cde off", 32'h40, 3'd1, 1, 0, 0, 2'd1, 1);
        nx_cde = 1'b1;
        step("R8 VS cde on", 32'h40, 3'd1, 0, 1, 64'h3, 2'd1, 1);
        step("R8 VU", 32'h40, 3'd1, 1, 0, 0, 2'd0, 1);
        step("R8 VU out of range", 32'h10, 3'd1, 1, 0, 0, 2'd0, 1);
        step("R8 M ignores virt", 32'h40, 3'd1, 1, 0, 0, 2'd3, 1);
        // R9 state-enable gate
        nx_stateen = 1'b0;
        step("R9 S gated", 32'h40, 3'd1, 1, 0, 0, 2'd1, 0);
        step("R9 VU gated", 32'h40, 3'd1, 1, 0, 0, 2'd0, 1);
        step("R9 M not gated", 32'h40, 3'd4, 1, 0, 0, 2'd3, 0);
        nx_stateen = 1'b1;
        // R11 mode and range
        step("R11 plain U", 32'h40, 3'd1, 1, 0, 0, 2'd0, 0);
        step("R11 below range", 32'h3F, 3'd1, 1, 0, 0, 2'd3, 0);
        step("R11 above range write", 32'h60, 3'd1, 0, 1, 64'hFFFF, 2'd1, 0);
        step("R11 ctr0 unchanged", 32'h40, 3'd1, 1, 0, 0, 2'd3, 0);
        step("R11 idle", 32'h40, 3'd1, 0, 0, 0, 2'd3, 0);
        step("R11 idle", 32'h0, 3'd0, 0, 0, 0, 2'd3, 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule